// File: doc/BRIEF.md
# Serial Port FIFO Controller

This block sits between a processor register bus and the bit-level shifters of an asynchronous serial port. It buffers outgoing bytes in a transmit queue and incoming bytes in a receive queue. Each queue holds 32 entries of 8 bits by default. Software reaches both queues through one word-addressed register port. That port offers a transmit data slot, a receive data slot, one control word per queue, a packed level word, an interrupt enable word and a pending word that is cleared by writing ones.

The transmit shifter takes bytes through a valid/pop pair. The receive shifter delivers bytes through a push strobe. Each queue has a programmable threshold. The transmit side requests service when the queue drains down to its threshold. The receive side requests service when the queue fills up to its threshold. A push into a full receive queue is an overrun and raises the error source. A fourth request line shows that the transmit queue has room.

Register word addresses on `reg_addr`: 0 transmit data (write only), 1 receive data (read only), 2 transmit control, 3 receive control, 4 levels (read only), 5 interrupt enable, 6 interrupt pending. Any address or bit not listed reads 0.

Top module: `sio_fifo_ctrl`

## Requirements
- R1: After reset both queues are empty and both queue enables and both thresholds are 0. The interrupt enable and pending words read 0, all four request outputs are low, and the level word reads 0x2000_0000 (32 free transmit entries).
- R2: Bytes written to address 0 leave on `txq_data` in the order written, one per cycle that `txq_pop` is high. `txq_valid` is high exactly when the transmit queue is enabled and not empty.
- R3: A write to address 0 while the transmit free count is 0 is discarded. The queue contents and the level word do not change.
- R4: A receive push stores `rxq_data` when the receive queue is enabled. A read of address 1 returns the oldest byte in bits 7:0 and removes it. A read of address 1 on an empty queue returns 0 and removes nothing.
- R5: A receive push while the receive queue holds 32 bytes is discarded, and it sets pending bit 2 (error).
- R6: In a control word, bit 0 is the queue enable, bit 1 is the flush and bits 13:8 are the threshold. Writing 1 to bit 1 empties that queue at that clock edge. Bit 1 always reads back 0. Bits 0 and 13:8 read back as written.
- R7: The level word holds the receive fill count in bits 5:0, the transmit fill count in bits 13:8 and the transmit free count (32 minus the fill) in bits 29:24.
- R8: Pending bit 1 sets when the receive queue is enabled and its fill rises from below the threshold to at or above it. Pending bit 0 sets when the transmit queue is enabled and its fill drops from above the threshold to at or below it. Enabling a queue whose level already meets the condition also counts as a rise.
- R9: Writing address 6 clears each pending bit (0 transmit, 1 receive, 2 error) that has a 1 in the written data. Bits written 0 are unchanged. A new set in the same cycle takes priority over the clear.
- R10: `irq_tx`, `irq_rx` and `irq_err` equal pending bits 0, 1 and 2 each ANDed with enable bits 0, 1 and 2. `irq_txroom` equals enable bit 3 ANDed with a nonzero transmit free count.
- R11: While a queue's enable is 0, receive pushes are ignored without an overrun, and `txq_valid` stays low, so `txq_pop` removes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the receive queue at address 1) |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| txq_valid | output | 1 | Transmit byte available to the shifter |
| txq_data | output | 8 | Oldest transmit byte |
| txq_pop | input | 1 | Shifter takes the transmit byte |
| rxq_push | input | 1 | Shifter delivers a received byte |
| rxq_data | input | 8 | Received byte |
| irq_tx | output | 1 | Transmit threshold request |
| irq_rx | output | 1 | Receive threshold request |
| irq_err | output | 1 | Receive overrun request |
| irq_txroom | output | 1 | Transmit queue has a free entry |

## Verification
The assertions assume that `reg_wr` and `reg_rd` are never high in the same cycle. They also assume that the register strobes and the shifter strobes are stable across the rising edge and that each strobe is meant for exactly one edge. The bench drives every input on the falling edge, holds each strobe for a single cycle and never issues a read and a write together. It reads the combinational read data shortly after driving the address. The sweeps cover every fill level from empty to full and one step past on both queues. They also run the receive threshold over values from 1 to the full depth and check that the pending bit stays clear one byte short of each threshold.

// File: rtl/sio_fifo_pkg.sv
`timescale 1ns/1ps
package sio_fifo_pkg;

   // word addresses of the register port
   typedef enum logic [2:0] {
      A_TXDATA  = 3'd0,
      A_RXDATA  = 3'd1,
      A_TXCTL   = 3'd2,
      A_RXCTL   = 3'd3,
      A_LEVELS  = 3'd4,
      A_IRQEN   = 3'd5,
      A_IRQPEND = 3'd6
   } reg_addr_e;

   localparam int REG_W       = 32;
   localparam int FIELD_W     = 6;
   // control word layout
   localparam int CTL_EN_BIT  = 0;
   localparam int CTL_FLU_BIT = 1;
   localparam int CTL_TRG_LSB = 8;
   // level word layout
   localparam int LV_RX_LSB   = 0;
   localparam int LV_TX_LSB   = 8;
   localparam int LV_FREE_LSB = 24;
   // interrupt source positions
   localparam int SRC_TX      = 0;
   localparam int SRC_RX      = 1;
   localparam int SRC_ERR     = 2;
   localparam int SRC_ROOM    = 3;
   localparam int N_PEND      = 3;
   localparam int N_IEN       = 4;

   typedef struct packed {
      logic [FIELD_W-1:0] trig;
      logic               en;
   } qctl_t;

endpackage

// File: rtl/sio_queue.sv
`timescale 1ns/1ps
module sio_queue #(
   parameter int DW    = 8,
   parameter int DEPTH = 32
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         flush,
   input  logic                         push,
   input  logic [DW-1:0]                push_data,
   input  logic                         pop,
   output logic [DW-1:0]                head,
   output logic [$clog2(DEPTH+1)-1:0]   count,
   output logic                         full,
   output logic                         empty
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   logic [DW-1:0] mem [DEPTH];
   logic [PW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic          push_ok, pop_ok;

   assign full    = (count == CW'(DEPTH));
   assign empty   = (count == '0);
   assign push_ok = push && !full && !flush;
   assign pop_ok  = pop && !empty && !flush;
   assign head    = mem[rd_ptr];

   generate
      if ((1 << PW) == DEPTH) begin : g_pow2
         assign wr_nxt = wr_ptr + PW'(1);
         assign rd_nxt = rd_ptr + PW'(1);
      end else begin : g_wrap
         assign wr_nxt = (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + PW'(1);
         assign rd_nxt = (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + PW'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push_ok) mem[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_nxt;
         if (pop_ok)  rd_ptr <= rd_nxt;
         count <= count + CW'(push_ok) - CW'(pop_ok);
      end
   end

   assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));

   assert_flush_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (count == '0));

   assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop && !flush) |=> (count == $past(count)));

endmodule

// File: rtl/sio_irq_pend.sv
`timescale 1ns/1ps
module sio_irq_pend #(
   parameter int           N         = 3,
   parameter logic [N-1:0] EDGE_MASK = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] raw,
   input  logic [N-1:0] clr,
   output logic [N-1:0] pend
);
   logic [N-1:0] set_v;

   for (genvar i = 0; i < N; i++) begin : g_src
      if (EDGE_MASK[i]) begin : g_edge
         logic prev;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev <= 1'b0;
            else        prev <= raw[i];
         end
         assign set_v[i] = raw[i] && !prev;
      end else begin : g_pulse
         assign set_v[i] = raw[i];
      end

      assert_w1c_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (clr[i] && !set_v[i]) |=> !pend[i]);

      assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
         set_v[i] |=> pend[i]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend <= '0;
      else        pend <= set_v | (pend & ~clr);
   end

endmodule

// File: rtl/sio_fifo_ctrl.sv
`timescale 1ns/1ps
module sio_fifo_ctrl
   import sio_fifo_pkg::*;
#(
   parameter int DW    = 8,
   parameter int DEPTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic             reg_rd,
   input  logic [2:0]       reg_addr,
   input  logic [31:0]      reg_wdata,
   output logic [31:0]      reg_rdata,
   output logic             txq_valid,
   output logic [DW-1:0]    txq_data,
   input  logic             txq_pop,
   input  logic             rxq_push,
   input  logic [DW-1:0]    rxq_data,
   output logic             irq_tx,
   output logic             irq_rx,
   output logic             irq_err,
   output logic             irq_txroom
);
   localparam int CW = $clog2(DEPTH + 1);
   localparam logic [FIELD_W-1:0] DEPTH_F = FIELD_W'(DEPTH);

   generate
      if (DEPTH < 2 || CW > FIELD_W) begin : g_bad_depth
         $error("sio_fifo_ctrl: DEPTH must lie in 2..63");
      end
      if (DW < 1 || DW > REG_W) begin : g_bad_width
         $error("sio_fifo_ctrl: DW must lie in 1..32");
      end
   endgenerate

   // decode
   logic wr_txd, rd_rxd, wr_txc, wr_rxc, wr_ien, wr_clr;
   assign wr_txd = reg_wr && (reg_addr == A_TXDATA);
   assign rd_rxd = reg_rd && (reg_addr == A_RXDATA);
   assign wr_txc = reg_wr && (reg_addr == A_TXCTL);
   assign wr_rxc = reg_wr && (reg_addr == A_RXCTL);
   assign wr_ien = reg_wr && (reg_addr == A_IRQEN);
   assign wr_clr = reg_wr && (reg_addr == A_IRQPEND);

   // control words
   qctl_t txc, rxc;
   logic  tx_flush, rx_flush;
   logic [N_IEN-1:0] ien;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         txc <= '0;
         rxc <= '0;
         ien <= '0;
      end else begin
         if (wr_txc) txc <= '{trig: reg_wdata[CTL_TRG_LSB +: FIELD_W],
                              en:   reg_wdata[CTL_EN_BIT]};
         if (wr_rxc) rxc <= '{trig: reg_wdata[CTL_TRG_LSB +: FIELD_W],
                              en:   reg_wdata[CTL_EN_BIT]};
         if (wr_ien) ien <= reg_wdata[N_IEN-1:0];
      end
   end

   assign tx_flush = wr_txc && reg_wdata[CTL_FLU_BIT];
   assign rx_flush = wr_rxc && reg_wdata[CTL_FLU_BIT];

   // queues
   logic [DW-1:0] tx_head, rx_head;
   logic [CW-1:0] tx_cnt, rx_cnt;
   logic          tx_full, tx_empty, rx_full, rx_empty;
   logic          rx_push_en, tx_pop_en;

   assign tx_pop_en  = txq_pop && txc.en;
   assign rx_push_en = rxq_push && rxc.en;

   sio_queue #(.DW(DW), .DEPTH(DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n), .flush(tx_flush),
      .push(wr_txd), .push_data(reg_wdata[DW-1:0]), .pop(tx_pop_en),
      .head(tx_head), .count(tx_cnt), .full(tx_full), .empty(tx_empty));

   sio_queue #(.DW(DW), .DEPTH(DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n), .flush(rx_flush),
      .push(rx_push_en), .push_data(rxq_data), .pop(rd_rxd),
      .head(rx_head), .count(rx_cnt), .full(rx_full), .empty(rx_empty));

   assign txq_valid = txc.en && !tx_empty;
   assign txq_data  = tx_head;

   // levels
   logic [FIELD_W-1:0] tx_lvl, rx_lvl, tx_free;
   assign tx_lvl  = FIELD_W'(tx_cnt);
   assign rx_lvl  = FIELD_W'(rx_cnt);
   assign tx_free = DEPTH_F - tx_lvl;

   // interrupt sources
   logic              tx_cond, rx_cond, overrun;
   logic [N_PEND-1:0] pend, clr_v;

   assign tx_cond = txc.en && (tx_lvl <= txc.trig);
   assign rx_cond = rxc.en && (rx_lvl >= rxc.trig);
   assign overrun = rx_push_en && rx_full && !rx_flush;
   assign clr_v   = wr_clr ? reg_wdata[N_PEND-1:0] : '0;

   sio_irq_pend #(.N(N_PEND), .EDGE_MASK(3'b011)) u_pend (
      .clk(clk), .rst_n(rst_n),
      .raw({overrun, rx_cond, tx_cond}),
      .clr(clr_v), .pend(pend));

   assign irq_tx     = pend[SRC_TX]  && ien[SRC_TX];
   assign irq_rx     = pend[SRC_RX]  && ien[SRC_RX];
   assign irq_err    = pend[SRC_ERR] && ien[SRC_ERR];
   assign irq_txroom = ien[SRC_ROOM] && (tx_free != '0);

   // read mux
   always_comb begin
      reg_rdata = '0;
      if (reg_rd) begin
         case (reg_addr_e'(reg_addr))
            A_RXDATA: if (!rx_empty) reg_rdata[DW-1:0] = rx_head;
            A_TXCTL: begin
               reg_rdata[CTL_EN_BIT]              = txc.en;
               reg_rdata[CTL_TRG_LSB +: FIELD_W]  = txc.trig;
            end
            A_RXCTL: begin
               reg_rdata[CTL_EN_BIT]              = rxc.en;
               reg_rdata[CTL_TRG_LSB +: FIELD_W]  = rxc.trig;
            end
            A_LEVELS: begin
               reg_rdata[LV_RX_LSB   +: FIELD_W]  = rx_lvl;
               reg_rdata[LV_TX_LSB   +: FIELD_W]  = tx_lvl;
               reg_rdata[LV_FREE_LSB +: FIELD_W]  = tx_free;
            end
            A_IRQEN:   reg_rdata[N_IEN-1:0]  = ien;
            A_IRQPEND: reg_rdata[N_PEND-1:0] = pend;
            default:   reg_rdata = '0;
         endcase
      end
   end

   logic unused_wdata;
   assign unused_wdata = ^reg_wdata;

   // checks next to the logic they guard
   assert_empty_read_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_rxd && rx_empty) |-> (reg_rdata == '0));

   assert_full_write_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_txd && tx_full && !tx_pop_en && !tx_flush) |=> (tx_cnt == $past(tx_cnt)));

   assert_overrun_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rxq_push && rxc.en && rx_full && !rx_flush) |=> pend[SRC_ERR]);

   assert_disabled_push_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (rxq_push && !rxc.en && !rd_rxd && !rx_flush) |=> (rx_cnt == $past(rx_cnt)));

   assert_tx_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!txc.en && !wr_txd && !tx_flush) |=> (tx_cnt == $past(tx_cnt)));

   assert_flush_reads_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && (reg_addr == A_TXCTL || reg_addr == A_RXCTL)) |-> !reg_rdata[CTL_FLU_BIT]);

endmodule

// File: tb/sio_fifo_ctrl_test.sv
`timescale 1ns/1ps
module sio_fifo_ctrl_test;
   localparam int DEPTH = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        txq_valid, txq_pop = 1'b0;
   logic [7:0]  txq_data;
   logic        rxq_push = 1'b0;
   logic [7:0]  rxq_data = '0;
   logic        irq_tx, irq_rx, irq_err, irq_txroom;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   sio_fifo_ctrl #(.DW(8), .DEPTH(DEPTH)) uut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .txq_valid(txq_valid), .txq_data(txq_data), .txq_pop(txq_pop),
      .rxq_push(rxq_push), .rxq_data(rxq_data),
      .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_err(irq_err),
      .irq_txroom(irq_txroom));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = a;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic push(input logic [7:0] d);
      @(negedge clk);
      rxq_push = 1'b1; rxq_data = d;
      @(negedge clk);
      rxq_push = 1'b0;
   endtask

   task automatic pop(output logic v, output logic [7:0] d);
      @(negedge clk);
      #1 v = txq_valid; d = txq_data;
      txq_pop = 1'b1;
      @(negedge clk);
      txq_pop = 1'b0;
   endtask

   function automatic logic [31:0] lv(input int rxf, input int txf);
      return (32'(DEPTH - txf) << 24) | (32'(txf) << 8) | 32'(rxf);
   endfunction

   function automatic logic [7:0] txpat(input int i);
      return 8'((i * 37 + 5) & 8'hff);
   endfunction

   function automatic logic [7:0] rxpat(input int i);
      return 8'((i * 53 + 9) & 8'hff);
   endfunction

   initial begin
      #(200000 * 5);
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      if (!done) $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin
      logic [31:0] d;
      logic        v;
      logic [7:0]  b;
      int          trigs [5] = '{1, 2, 7, 16, 32};

      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(3'd4, d); chk("R1 levels", d, 32'h2000_0000);
      rd(3'd2, d); chk("R1 txctl", d, 0);
      rd(3'd3, d); chk("R1 rxctl", d, 0);
      rd(3'd5, d); chk("R1 irqen", d, 0);
      rd(3'd6, d); chk("R1 pend", d, 0);
      chk("R1 outputs", {27'd0, txq_valid, irq_tx, irq_rx, irq_err, irq_txroom}, 0);

      // transmit enable, threshold 4
      wr(3'd2, 32'h0000_0403);
      rd(3'd2, d); chk("R6 txctl readback", d, 32'h401);
      rd(3'd6, d); chk("R8 tx pend on enable", d, 1);
      chk("R10 irq_tx masked", {31'd0, irq_tx}, 0);
      wr(3'd5, 32'h9);
      chk("R10 irq_tx enabled", {30'd0, irq_tx, irq_txroom}, 2'b11);
      wr(3'd6, 32'h0);
      rd(3'd6, d); chk("R9 write zero keeps", d, 1);
      wr(3'd6, 32'h1);
      rd(3'd6, d); chk("R9 clear tx", d, 0);
      chk("R10 irq_tx after clear", {31'd0, irq_tx}, 0);

      // fill sweep
      for (int i = 0; i < DEPTH; i++) begin
         wr(3'd0, {24'd0, txpat(i)});
         rd(3'd4, d); chk("R7 tx fill sweep", d, lv(0, i + 1));
      end
      chk("R10 txroom at full", {31'd0, irq_txroom}, 0);
      wr(3'd0, 32'hEE);
      rd(3'd4, d); chk("R3 write when full", d, lv(0, DEPTH));
      rd(3'd6, d); chk("R8 no tx pend while filling", d, 0);

      // drain sweep
      for (int j = 0; j < DEPTH; j++) begin
         pop(v, b);
         chk("R2 txq_valid", {31'd0, v}, 1);
         chk("R2 tx order", {24'd0, b}, {24'd0, txpat(j)});
         if (j == 26) begin
            rd(3'd6, d); chk("R8 tx pend above trig", d, 0);
         end
      end
      rd(3'd6, d); chk("R8 tx pend at trig", d, 1);
      chk("R2 valid when empty", {31'd0, txq_valid}, 0);
      pop(v, b);
      rd(3'd4, d); chk("R2 pop empty", d, lv(0, 0));
      chk("R10 txroom nonfull", {31'd0, irq_txroom}, 1);

      // disabled transmit
      wr(3'd2, 32'h0000_0400);
      wr(3'd0, 32'h5A);
      chk("R11 tx valid disabled", {31'd0, txq_valid}, 0);
      pop(v, b);
      rd(3'd4, d); chk("R11 pop disabled", d, lv(0, 1));
      wr(3'd2, 32'h0000_0403);
      rd(3'd4, d); chk("R6 tx flush", d, lv(0, 0));
      wr(3'd6, 32'h7);
      rd(3'd6, d); chk("R9 clear all", d, 0);

      // disabled receive
      push(8'h11);
      rd(3'd4, d); chk("R11 rx push disabled", d, lv(0, 0));
      rd(3'd6, d); chk("R11 no overrun disabled", d, 0);
      wr(3'd5, 32'h7);

      // receive threshold sweep
      foreach (trigs[k]) begin
         wr(3'd3, (32'(trigs[k]) << 8) | 32'h3);
         for (int p = 0; p < trigs[k] - 1; p++) push(rxpat(p));
         rd(3'd6, d); chk("R8 rx below trig", d, 0);
         push(8'h77);
         rd(3'd4, d); chk("R7 rx fill", d, lv(trigs[k], 0));
         rd(3'd6, d); chk("R8 rx at trig", d, 2);
         chk("R10 irq_rx", {31'd0, irq_rx}, 1);
         wr(3'd6, 32'h2);
         rd(3'd6, d); chk("R9 clear rx", d, 0);
      end

      // overrun
      push(8'hAB);
      rd(3'd4, d); chk("R5 full unchanged", d, lv(DEPTH, 0));
      rd(3'd6, d); chk("R5 overrun pend", d, 4);
      chk("R10 irq_err", {31'd0, irq_err}, 1);
      wr(3'd6, 32'h4);

      // receive order
      wr(3'd3, 32'h0000_0103);
      for (int p = 0; p < DEPTH; p++) push(rxpat(p));
      push(8'hFF);
      for (int p = 0; p < DEPTH; p++) begin
         rd(3'd1, d); chk("R4 rx order", d, {24'd0, rxpat(p)});
      end
      rd(3'd1, d); chk("R4 read empty", d, 0);
      rd(3'd4, d); chk("R4 empty levels", d, lv(0, 0));

      // receive flush
      push(8'h01); push(8'h02); push(8'h03);
      rd(3'd4, d); chk("R7 mixed level", d, lv(3, 0));
      wr(3'd3, 32'h0000_0503);
      rd(3'd3, d); chk("R6 rxctl readback", d, 32'h501);
      rd(3'd4, d); chk("R6 rx flush", d, lv(0, 0));

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule